// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block decides, for a five-stage in-order pipeline whose branch comparison runs in the decode stage, where each operand value comes from and when decode must wait. Every cycle it compares the source register fields of the instruction in decode with the destination fields of the instructions now in execute and memory. It then produces three kinds of result. The first is an immediate bypass select for the decode-stage branch comparator. The second is a pair of bypass codes that travel with the instruction into execute, chosen in decode and registered alongside the decode/execute pipeline register. The third is a store-data bypass flag that travels on into the memory stage. It also raises a PC/fetch-register hold and a decode/execute bubble request when the value needed in decode cannot yet be supplied.

The register file is assumed to write in the first half of a cycle and read in the second half, so a producer in write-back needs no action from this block. Data memory is assumed to return load data early enough in the memory stage to feed the ALU in that same cycle. Because of that, a load followed directly by an ALU consumer costs no stall. A branch that depends on a producer still in execute must wait, and a branch that depends on a load waits two cycles.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A source field equal to register 0 never causes a stall, a branch bypass or a non-zero execute bypass code.
- R2: A producer in execute or memory whose register-write flag is low is ignored for both stalling and bypassing.
- R3: The execute bypass codes are registered. Code 0 takes the register file value, 1 takes the ALU result of the instruction then in memory, 2 takes the data memory read data of the load then in memory, and 3 takes the write-back value. A source matching a non-load producer in execute gives code 1 on the output one clock later.
- R4: A source matching a load in execute gives code 2 one clock later, with no stall, for the ALU, load and store classes.
- R5: A source matching a producer in memory (ALU or load) and no producer in execute gives code 3 one clock later.
- R6: When both the execute and the memory producer match the same source, the execute (younger) producer decides the code.
- R7: The instruction class field is 0 for ALU, 1 for load, 2 for store and 3 for branch. A branch whose used source matches a non-load producer in execute raises pc_hold and idex_bubble for that cycle.
- R8: A branch whose used source matches a load in execute stalls, and it stalls again while that load sits in memory, giving two stall cycles in total.
- R9: A branch whose used source matches a non-load producer in memory raises that operand's branch bypass select and does not stall.
- R10: A store whose data source (rt) matches a load in execute gets code 0 on the rt operand and raises mem_st_fwd two clocks later, so the stored data comes from the loaded word in write-back.
- R11: In the clock after a stall, both execute codes are 0 and mem_st_fwd is 0 one clock after that (bubble).
- R12: While rst_n is low at a clock edge, all registered outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | 5 | First source register of the decode-stage instruction |
| id_rt | input | 5 | Second source register (store data for stores) |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_cls | input | 2 | Decode instruction class (0 ALU, 1 load, 2 store, 3 branch) |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_mrd | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_mrd | input | 1 | Memory-stage instruction is a load |
| id_br_fwd_a | output | 1 | Branch comparator operand A takes the memory-stage ALU result |
| id_br_fwd_b | output | 1 | Branch comparator operand B takes the memory-stage ALU result |
| ex_fwd_a | output | 2 | Registered bypass code for execute operand A |
| ex_fwd_b | output | 2 | Registered bypass code for execute operand B |
| mem_st_fwd | output | 1 | Store in memory takes its data from the loaded word in write-back |
| pc_hold | output | 1 | Hold the PC and the fetch/decode register |
| idex_bubble | output | 1 | Load a cleared bubble into decode/execute |

## Verification
Each producer kind (ALU result or load) is placed in execute, in memory or in both, and each consumer class reads it. This separates code 1 from code 2 from code 3 and shows the execute-over-memory priority. The branch class is run against the same producers to tell a one-cycle stall, a two-cycle load stall and a stall-free branch bypass apart. Register 0 and producers with the write flag low are run through the same matching patterns to show that they are ignored. The store-after-load pattern checks that the data bypass moves to the memory-stage flag instead of an execute code.

// File: rtl/hz_pkg.sv
// Shared types for the hazard and forwarding unit.
// Assumes the class and bypass encodings below are fixed by the
// decoder and by the operand multiplexers in the datapath.
package hz_pkg;
    localparam int REG_AW = 5;
    localparam int CLS_W  = 2;
    localparam int FWD_W  = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_BRANCH = 2'd3
    } icls_t;

    typedef enum logic [FWD_W-1:0] {
        FW_REG = 2'd0,
        FW_ALU = 2'd1,
        FW_LDD = 2'd2,
        FW_WB  = 2'd3
    } fwd_t;
endpackage

// File: rtl/hz_src_fwd.sv
// Per-source hazard evaluation for one decode-stage source register.
// Produces the execute bypass code this source will need one stage
// later, the decode branch bypass select, a stall request and, for
// the store-data operand only, a store-data bypass request.
// Assumes register 0 is hard-wired to zero and a write-back producer
// is already visible through the register file.
module hz_src_fwd
    import hz_pkg::*;
#(
    parameter int RAW     = REG_AW,
    parameter int IS_DATA = 0
) (
    input  logic [RAW-1:0] src,
    input  logic           use_src,
    input  icls_t          cls,
    input  logic [RAW-1:0] ex_rd,
    input  logic           ex_we,
    input  logic           ex_mrd,
    input  logic [RAW-1:0] mem_rd,
    input  logic           mem_we,
    input  logic           mem_mrd,
    output fwd_t           code,
    output logic           br_fwd,
    output logic           need_stall,
    output logic           st_fwd
);
    logic live;
    logic hit_ex;
    logic hit_mem;
    logic is_br;
    logic ld_to_store;

    // Match this source against each producer that writes a real register.
    always_comb begin
        live    = use_src && (src != '0);
        hit_ex  = live && ex_we  && (ex_rd  == src);
        hit_mem = live && mem_we && (mem_rd == src);
        is_br   = (cls == CLS_BRANCH);
    end

    // Store data from a load one ahead is deferred to the memory stage.
    generate
        if (IS_DATA != 0) begin : g_data
            assign ld_to_store = (cls == CLS_STORE) && hit_ex && ex_mrd;
        end else begin : g_nodata
            assign ld_to_store = 1'b0;
        end
    endgenerate

    // Execute-stage code: the younger producer wins over the older one.
    always_comb begin
        if (ld_to_store)  code = FW_REG;
        else if (hit_ex)  code = ex_mrd ? FW_LDD : FW_ALU;
        else if (hit_mem) code = FW_WB;
        else              code = FW_REG;
    end

    // Decode-stage branch operand: stall unless a finished ALU result exists.
    always_comb begin
        need_stall = is_br && (hit_ex || (hit_mem && mem_mrd));
        br_fwd     = is_br && !hit_ex && hit_mem && !mem_mrd;
        st_fwd     = ld_to_store;
    end
endmodule

// File: rtl/hz_sel_pipe.sv
// Carries the bypass decisions from decode into execute and the
// store-data request on into the memory stage. A stall in decode
// turns the execute entry into a bubble with every select cleared.
// Assumes execute and memory always advance (only fetch/decode hold).
module hz_sel_pipe
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stall,
    input  logic [NSRC-1:0][FWD_W-1:0] code_id,
    input  logic                       st_id,
    output logic [NSRC-1:0][FWD_W-1:0] code_ex,
    output logic                       st_mem
);
    logic st_ex;

    // Decode to execute register, cleared by reset or by a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            code_ex <= '0;
            st_ex   <= 1'b0;
        end else begin
            code_ex <= code_id;
            st_ex   <= st_id;
        end
    end

    // Execute to memory register for the store-data request.
    always_ff @(posedge clk) begin
        if (!rst_n) st_mem <= 1'b0;
        else        st_mem <= st_ex;
    end
endmodule

// File: rtl/hz_stall_ctl.sv
// Folds per-source stall requests into the fetch hold and the
// decode/execute bubble. Both act in the same cycle by design.
module hz_stall_ctl #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] need,
    output logic            hold,
    output logic            bubble
);
    // Any source that cannot be served stops decode.
    always_comb begin
        hold   = |need;
        bubble = |need;
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Hazard detection and operand forwarding for a five-stage in-order
// pipeline with the branch comparison in decode. Sources are indexed
// 0 (rs, operand A) and 1 (rt, operand B and store data).
// Assumes write-before-read in the register file and load data that
// is usable by the ALU within the memory-stage cycle.
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int RAW  = REG_AW,
    parameter int NSRC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] id_rs,
    input  logic [RAW-1:0] id_rt,
    input  logic           id_use_rs,
    input  logic           id_use_rt,
    input  logic [1:0]     id_cls,
    input  logic [RAW-1:0] ex_rd,
    input  logic           ex_we,
    input  logic           ex_mrd,
    input  logic [RAW-1:0] mem_rd,
    input  logic           mem_we,
    input  logic           mem_mrd,
    output logic           id_br_fwd_a,
    output logic           id_br_fwd_b,
    output logic [1:0]     ex_fwd_a,
    output logic [1:0]     ex_fwd_b,
    output logic           mem_st_fwd,
    output logic           pc_hold,
    output logic           idex_bubble
);
    localparam int DATA_IDX = 1;

    logic [NSRC-1:0][RAW-1:0]   src;
    logic [NSRC-1:0]            use_v;
    logic [NSRC-1:0][FWD_W-1:0] code_id;
    logic [NSRC-1:0][FWD_W-1:0] code_ex;
    logic [NSRC-1:0]            br_v;
    logic [NSRC-1:0]            stall_v;
    logic [NSRC-1:0]            st_v;
    icls_t                      cls;

    // Gather the decode sources into indexed form.
    always_comb begin
        src[0]   = id_rs;
        src[1]   = id_rt;
        use_v[0] = id_use_rs;
        use_v[1] = id_use_rt;
        cls      = icls_t'(id_cls);
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            fwd_t code_g;
            hz_src_fwd #(
                .RAW     (RAW),
                .IS_DATA ((g == DATA_IDX) ? 1 : 0)
            ) u_src (
                .src        (src[g]),
                .use_src    (use_v[g]),
                .cls        (cls),
                .ex_rd      (ex_rd),
                .ex_we      (ex_we),
                .ex_mrd     (ex_mrd),
                .mem_rd     (mem_rd),
                .mem_we     (mem_we),
                .mem_mrd    (mem_mrd),
                .code       (code_g),
                .br_fwd     (br_v[g]),
                .need_stall (stall_v[g]),
                .st_fwd     (st_v[g])
            );
            assign code_id[g] = code_g;
        end
    endgenerate

    hz_stall_ctl #(.NSRC(NSRC)) u_stall (
        .need   (stall_v),
        .hold   (pc_hold),
        .bubble (idex_bubble)
    );

    hz_sel_pipe #(.NSRC(NSRC)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (pc_hold),
        .code_id (code_id),
        .st_id   (|st_v),
        .code_ex (code_ex),
        .st_mem  (mem_st_fwd)
    );

    // Present the per-source results on named ports.
    always_comb begin
        id_br_fwd_a = br_v[0];
        id_br_fwd_b = br_v[1];
        ex_fwd_a    = code_ex[0];
        ex_fwd_b    = code_ex[1];
    end
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
// Temporal properties of the hazard and forwarding unit, bound to
// every instance of the top module.
module hazard_fwd_unit_chk #(
    parameter int RAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [RAW-1:0] id_rs,
    input logic [RAW-1:0] id_rt,
    input logic           id_use_rs,
    input logic           id_use_rt,
    input logic [1:0]     id_cls,
    input logic [RAW-1:0] ex_rd,
    input logic           ex_we,
    input logic           ex_mrd,
    input logic [RAW-1:0] mem_rd,
    input logic           mem_we,
    input logic           mem_mrd,
    input logic           id_br_fwd_a,
    input logic           id_br_fwd_b,
    input logic [1:0]     ex_fwd_a,
    input logic [1:0]     ex_fwd_b,
    input logic           mem_st_fwd,
    input logic           pc_hold,
    input logic           idex_bubble
);
    logic rs_ex_alu;
    logic rs_mem_ld;
    logic rt_ex_ld;
    logic any_use;

    always_comb begin
        rs_ex_alu = id_use_rs && (id_rs != '0) && ex_we && !ex_mrd && (ex_rd == id_rs);
        rs_mem_ld = id_use_rs && (id_rs != '0) && mem_we && mem_mrd && (mem_rd == id_rs);
        rt_ex_ld  = id_use_rt && (id_rt != '0) && ex_we && ex_mrd && (ex_rd == id_rt);
        any_use   = id_use_rs | id_use_rt | idex_bubble | id_br_fwd_a | id_br_fwd_b;
    end

    a_r1_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0 && id_rt == '0) |-> (!pc_hold && !id_br_fwd_a && !id_br_fwd_b));

    a_r1_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0 && id_rt == '0) |=> (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0));

    a_r2_no_writers: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we) |-> (!pc_hold && !id_br_fwd_a && !id_br_fwd_b));

    a_r3_alu_code: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cls == 2'd0 && rs_ex_alu) |=> (ex_fwd_a == 2'd1));

    a_r4_load_nostall: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cls != 2'd3) |-> !pc_hold);

    a_r8_load_branch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cls == 2'd3 && rs_mem_ld) |-> pc_hold);

    a_r10_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cls == 2'd2 && rt_ex_ld) |=> ##1 mem_st_fwd);

    a_r11_bubble_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0));

    a_r12_reset_clear: assert property (@(posedge clk)
        (!rst_n && any_use) |=> (!rst_n || !mem_st_fwd || $past(rst_n)) );
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.RAW(RAW)) u_chk (.*);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] id_rs, id_rt, ex_rd, mem_rd;
    logic       id_use_rs, id_use_rt, ex_we, ex_mrd, mem_we, mem_mrd;
    logic [1:0] id_cls;
    logic       id_br_fwd_a, id_br_fwd_b, mem_st_fwd, pc_hold, idex_bubble;
    logic [1:0] ex_fwd_a, ex_fwd_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_fwd_unit u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0; id_cls = 2'd0;
        ex_rd = 0; ex_we = 0; ex_mrd = 0;
        mem_rd = 0; mem_we = 0; mem_mrd = 0;
    endtask

    task automatic consumer(input logic [1:0] c, input logic [4:0] rs, input logic [4:0] rt);
        id_cls = c; id_rs = rs; id_rt = rt; id_use_rs = 1; id_use_rt = 1;
    endtask

    task automatic t_reset();
        idle();
        rst_n = 0;
        consumer(2'd0, 5'd3, 5'd3); ex_rd = 3; ex_we = 1;
        step(); step();
        chk("R12 ex_fwd_a", ex_fwd_a, 0);
        chk("R12 ex_fwd_b", ex_fwd_b, 0);
        chk("R12 mem_st_fwd", mem_st_fwd, 0);
        rst_n = 1; idle(); step();
    endtask

    task automatic t_zero_reg();
        consumer(2'd3, 5'd0, 5'd0); ex_rd = 0; ex_we = 1; mem_rd = 0; mem_we = 1;
        #1 chk("R1 hold", pc_hold, 0);
        chk("R1 br_fwd_a", id_br_fwd_a, 0);
        consumer(2'd0, 5'd0, 5'd0);
        step();
        chk("R1 ex_fwd_a", ex_fwd_a, 0);
        idle();
    endtask

    task automatic t_we_low();
        consumer(2'd3, 5'd6, 5'd6); ex_rd = 6; ex_we = 0; mem_rd = 6; mem_we = 0;
        #1 chk("R2 hold", pc_hold, 0);
        chk("R2 br_fwd_b", id_br_fwd_b, 0);
        consumer(2'd0, 5'd6, 5'd6);
        step();
        chk("R2 ex_fwd_b", ex_fwd_b, 0);
        idle();
    endtask

    task automatic t_alu_ex();
        consumer(2'd0, 5'd8, 5'd9); ex_rd = 8; ex_we = 1;
        #1 chk("R3 no stall", pc_hold, 0);
        step();
        chk("R3 ex_fwd_a", ex_fwd_a, 1);
        chk("R3 ex_fwd_b", ex_fwd_b, 0);
        idle();
    endtask

    task automatic t_load_ex();
        consumer(2'd0, 5'd2, 5'd10); ex_rd = 10; ex_we = 1; ex_mrd = 1;
        #1 chk("R4 no stall", pc_hold, 0);
        step();
        chk("R4 ex_fwd_b", ex_fwd_b, 2);
        chk("R4 ex_fwd_a", ex_fwd_a, 0);
        idle();
    endtask

    task automatic t_mem_wb();
        consumer(2'd1, 5'd11, 5'd0); mem_rd = 11; mem_we = 1; mem_mrd = 1;
        step();
        chk("R5 load producer", ex_fwd_a, 3);
        consumer(2'd0, 5'd0, 5'd12); mem_rd = 12; mem_we = 1; mem_mrd = 0;
        step();
        chk("R5 alu producer", ex_fwd_b, 3);
        idle();
    endtask

    task automatic t_priority();
        consumer(2'd0, 5'd13, 5'd0); ex_rd = 13; ex_we = 1; mem_rd = 13; mem_we = 1;
        step();
        chk("R6 younger alu", ex_fwd_a, 1);
        consumer(2'd0, 5'd13, 5'd0); ex_rd = 13; ex_we = 1; ex_mrd = 1;
        mem_rd = 13; mem_we = 1; mem_mrd = 0;
        step();
        chk("R6 younger load", ex_fwd_a, 2);
        idle();
    endtask

    task automatic t_br_alu();
        consumer(2'd3, 5'd14, 5'd15); ex_rd = 15; ex_we = 1;
        #1 chk("R7 hold", pc_hold, 1);
        chk("R7 bubble", idex_bubble, 1);
        step();
        chk("R11 bubble code b", ex_fwd_b, 0);
        ex_we = 0; mem_rd = 15; mem_we = 1;
        #1 chk("R7 released", pc_hold, 0);
        chk("R9 br_fwd_b", id_br_fwd_b, 1);
        chk("R9 br_fwd_a", id_br_fwd_a, 0);
        step();
        idle();
    endtask

    task automatic t_br_load();
        int stalls = 0;
        consumer(2'd3, 5'd16, 5'd0); ex_rd = 16; ex_we = 1; ex_mrd = 1;
        #1 stalls += pc_hold;
        step();
        chk("R11 bubble code a", ex_fwd_a, 0);
        ex_we = 0; ex_mrd = 0; mem_rd = 16; mem_we = 1; mem_mrd = 1;
        #1 stalls += pc_hold;
        chk("R8 no br bypass from load", id_br_fwd_a, 0);
        step();
        mem_we = 0; mem_mrd = 0;
        #1 stalls += pc_hold;
        chk("R8 stall count", stalls, 2);
        step();
        idle();
    endtask

    task automatic t_store_fwd();
        consumer(2'd2, 5'd4, 5'd17); ex_rd = 17; ex_we = 1; ex_mrd = 1;
        #1 chk("R10 no stall", pc_hold, 0);
        step();
        idle();
        chk("R10 ex_fwd_b", ex_fwd_b, 0);
        chk("R10 not yet", mem_st_fwd, 0);
        step();
        chk("R10 mem_st_fwd", mem_st_fwd, 1);
        step();
        chk("R10 one cycle", mem_st_fwd, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_zero_reg();
        t_we_low();
        t_alu_ex();
        t_load_ex();
        t_mem_wb();
        t_priority();
        t_br_alu();
        t_br_load();
        t_store_fwd();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule